// File: doc/BRIEF.md
# Parallel Bus Slave Interface with Shared-RAM Hold and Mailbox Ports

This block is the slave side of an asynchronous, parallel system bus. It sits in front of a local signal-processing core that runs from fast local RAM. A bus master drives an address and then one of four commands: memory read, memory write, I/O read or I/O write. The block checks whether the address falls in its memory window or its I/O port window. If it does, the block completes the cycle with an acknowledge that it holds until the master removes the command. Addresses outside both windows get no response.

A memory cycle has to reach RAM that the local core normally owns. The block therefore raises a hold request to the core, waits for the hold acknowledge, and performs one RAM access. It then acknowledges the bus and keeps the core on hold until the master ends the cycle. While no memory cycle is in progress the core is never held, so it runs with no wait states. Transfers are 16 bits wide, or 8 bits wide on the low byte lane.

The I/O window holds four ports. Port 0 is a pair of handshaked one-word mailboxes, one for each direction. Port 1 is a status word. Port 2 is a four-level interrupt register that the bus can write, and it raises prioritised interrupts to the core. Port 3 is reserved.

The FSM has five named states:
- IDLE: waits for a decoded command.
- HOLD_WAIT: the hold request is raised and the block waits for the grant.
- RAM_XFER: the single RAM strobe.
- MEM_DONE: acknowledge given with the core still held.
- IO_DONE: acknowledge given for an I/O cycle.

The transitions are:
- IDLE to HOLD_WAIT on a memory hit.
- IDLE to IO_DONE on an I/O hit.
- HOLD_WAIT to RAM_XFER once the hold acknowledge is seen.
- RAM_XFER to MEM_DONE unconditionally.
- MEM_DONE or IO_DONE back to IDLE once all commands are low.

Top module: `bsi_slave`

## Requirements
- R1: After reset, bus_ack, core_hold_req, ram_en, both mailbox full flags and core_irq_req are low, and the status word reads 0.
- R2: A memory command whose bits [23:12] differ from the window base 0x040, or an I/O command whose bits [15:2] differ from the port base 0x0080, gets no acknowledge, no hold request and no RAM strobe. RAM, mailbox, status and interrupt state stay unchanged.
- R3: On a memory hit, core_hold_req rises one clock after the command is seen. ram_en pulses for exactly one clock, only after core_hold_ack has been sampled high. bus_ack rises the clock after that pulse, so with the grant arriving h cycles late the acknowledge comes 3+h clocks after the command.
- R4: A memory write stores bus_wdata at word address bus_addr[11:0]: both bytes when bus_wide=1, the low byte only when bus_wide=0. A memory read returns the stored word, or the low byte zero-extended when bus_wide=0.
- R5: bus_ack stays high while any command is asserted. It drops, together with core_hold_req, one clock after all commands are removed.
- R6: An I/O hit is acknowledged one clock after the command is seen.
- R7: An I/O write to port 0 fills the bus-to-core mailbox and sets core_in_full. A core_mb_rd pulse clears the flag. A bus write while the flag is set is ignored and sets a sticky bus-side overrun bit.
- R8: A core_mb_wr pulse fills the core-to-bus mailbox and sets core_out_full. An I/O read of port 0 returns the word and clears the flag. A core write while the flag is set is ignored and sets a sticky core-side overrun bit.
- R9: An I/O read of port 1 returns the status word: bit0 core_in_full, bit1 core_out_full, bit2 bus-side overrun, bit3 core-side overrun, all other bits 0.
- R10: An I/O write to port 2 ORs bus_wdata[3:0] into the pending interrupt set, and an I/O read of port 2 returns it. core_irq_req is high when any level is pending. core_irq_lvl gives the highest pending level, with level 3 highest. A core_irq_ack pulse clears that level.
- R11: core_hold_req is high only from the decoded memory command until the end of its acknowledge. It is never raised during an I/O cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 24 | Bus address (I/O cycles use the low 16 bits) |
| bus_wdata | input | 16 | Bus write data |
| bus_wide | input | 1 | 1 = 16-bit transfer, 0 = 8-bit transfer on the low lane |
| bus_mem_rd | input | 1 | Memory read command |
| bus_mem_wr | input | 1 | Memory write command |
| bus_io_rd | input | 1 | I/O read command |
| bus_io_wr | input | 1 | I/O write command |
| bus_rdata | output | 16 | Bus read data, valid while bus_ack is high |
| bus_ack | output | 1 | Transfer acknowledge |
| core_hold_req | output | 1 | Hold request to the local core |
| core_hold_ack | input | 1 | Hold granted by the local core |
| ram_addr | output | 12 | Shared RAM word address |
| ram_wdata | output | 16 | Shared RAM write data |
| ram_be | output | 2 | Shared RAM byte enables |
| ram_en | output | 1 | Shared RAM access strobe |
| ram_we | output | 1 | Shared RAM write enable |
| ram_rdata | input | 16 | Shared RAM read data, valid during the strobe |
| core_mb_rd | input | 1 | Core consumes the bus-to-core mailbox |
| core_mb_rdata | output | 16 | Bus-to-core mailbox contents |
| core_in_full | output | 1 | Bus-to-core mailbox holds an unread word |
| core_mb_wr | input | 1 | Core writes the core-to-bus mailbox |
| core_mb_wdata | input | 16 | Core-to-bus mailbox write data |
| core_out_full | output | 1 | Core-to-bus mailbox holds an unread word |
| core_irq_req | output | 1 | Any interrupt level pending |
| core_irq_lvl | output | 2 | Highest pending interrupt level |
| core_irq_ack | input | 1 | Core clears the level shown on core_irq_lvl |

## Verification
An I/O acknowledge is due on the first clock after the command. A memory acknowledge is due on clock 3+h, where the bench's model of the core grants hold h clocks late, with h varied from 0 to 3. The bench counts falling edges from the one where it drives the command and compares that count, and the read data, exactly at the edge where bus_ack is first seen. Release is checked one falling edge after the command is dropped. Mailbox flags and interrupt outputs are sampled on the falling edge after the pulse that changes them, because each is one register stage from its cause.

// File: rtl/bsi_pkg.sv
package bsi_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HOLD_WAIT,
        ST_RAM_XFER,
        ST_MEM_DONE,
        ST_IO_DONE
    } bsi_state_e;

    typedef enum logic [1:0] {
        PORT_MBOX = 2'd0,
        PORT_STAT = 2'd1,
        PORT_IRQ  = 2'd2,
        PORT_RSVD = 2'd3
    } bsi_port_e;

    localparam int BSI_ADDR_W    = 24;
    localparam int BSI_IO_W      = 16;
    localparam int BSI_PORT_BITS = 2;

endpackage

// File: rtl/bsi_decode.sv
module bsi_decode #(
    parameter int ADDR_W    = 24,
    parameter int IO_W      = 16,
    parameter int RAM_AW    = 12,
    parameter int PORT_BITS = 2,
    parameter logic [ADDR_W-1:0] MEM_BASE = 24'h040000,
    parameter logic [IO_W-1:0]   IO_BASE  = 16'h0080
) (
    input  logic [ADDR_W-1:0]    addr,
    output logic                 mem_hit,
    output logic                 io_hit,
    output logic [RAM_AW-1:0]    ram_word,
    output logic [PORT_BITS-1:0] port_sel
);

    always_comb begin
        mem_hit  = (addr[ADDR_W-1:RAM_AW] == MEM_BASE[ADDR_W-1:RAM_AW]);
        io_hit   = (addr[IO_W-1:PORT_BITS] == IO_BASE[IO_W-1:PORT_BITS]);
        ram_word = addr[RAM_AW-1:0];
        port_sel = addr[PORT_BITS-1:0];
    end

endmodule

// File: rtl/bsi_mbox.sv
module bsi_mbox #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         rd,
    output logic [W-1:0] data,
    output logic         full,
    output logic         ovr
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data <= '0;
            full <= 1'b0;
            ovr  <= 1'b0;
        end else begin
            if (rd) begin
                full <= 1'b0;
            end
            if (wr) begin
                if (full) begin
                    ovr <= 1'b1;
                end else begin
                    data <= wdata;
                    full <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/bsi_irq.sv
module bsi_irq #(
    parameter int LEVELS = 4,
    localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en,
    input  logic [LEVELS-1:0] set_bits,
    input  logic              ack,
    output logic [LEVELS-1:0] pend,
    output logic              req,
    output logic [LVL_W-1:0]  lvl
);

    logic [LEVELS-1:0] clr_mask;

    always_comb begin
        lvl = '0;
        for (int i = 0; i < LEVELS; i++) begin
            if (pend[i]) begin
                lvl = LVL_W'(i);
            end
        end
        req = |pend;
        clr_mask = '0;
        for (int i = 0; i < LEVELS; i++) begin
            if (ack && req && (LVL_W'(i) == lvl)) begin
                clr_mask[i] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= '0;
        end else begin
            pend <= (pend & ~clr_mask) | (set_en ? set_bits : '0);
        end
    end

endmodule

// File: rtl/bsi_slave.sv
module bsi_slave
    import bsi_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int RAM_AW     = 12,
    parameter int IRQ_LEVELS = 4,
    parameter logic [BSI_ADDR_W-1:0] MEM_BASE = 24'h040000,
    parameter logic [BSI_IO_W-1:0]   IO_BASE  = 16'h0080,
    localparam int BYTE_W = DATA_W / 2,
    localparam int LVL_W  = (IRQ_LEVELS > 1) ? $clog2(IRQ_LEVELS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [BSI_ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    input  logic                  bus_wide,
    input  logic                  bus_mem_rd,
    input  logic                  bus_mem_wr,
    input  logic                  bus_io_rd,
    input  logic                  bus_io_wr,
    output logic [DATA_W-1:0]     bus_rdata,
    output logic                  bus_ack,
    output logic                  core_hold_req,
    input  logic                  core_hold_ack,
    output logic [RAM_AW-1:0]     ram_addr,
    output logic [DATA_W-1:0]     ram_wdata,
    output logic [1:0]            ram_be,
    output logic                  ram_en,
    output logic                  ram_we,
    input  logic [DATA_W-1:0]     ram_rdata,
    input  logic                  core_mb_rd,
    output logic [DATA_W-1:0]     core_mb_rdata,
    output logic                  core_in_full,
    input  logic                  core_mb_wr,
    input  logic [DATA_W-1:0]     core_mb_wdata,
    output logic                  core_out_full,
    output logic                  core_irq_req,
    output logic [LVL_W-1:0]      core_irq_lvl,
    input  logic                  core_irq_ack
);

    bsi_state_e state_q, state_d;

    logic                     mem_hit, io_hit;
    logic [RAM_AW-1:0]        dec_word;
    logic [BSI_PORT_BITS-1:0] dec_port;
    bsi_port_e                port_e;

    logic mem_cmd, io_cmd, cmd_any;
    logic mem_go, io_go;

    logic [RAM_AW-1:0]  lat_word;
    logic [DATA_W-1:0]  lat_wdata;
    logic               lat_wr;
    logic               lat_wide;
    logic [DATA_W-1:0]  rdata_q;

    logic               in_wr, out_rd, irq_set;
    logic [DATA_W-1:0]  out_data;
    logic               in_ovr_w, out_ovr_w;
    logic [IRQ_LEVELS-1:0] irq_pend;
    logic [DATA_W-1:0]  io_rword;

    bsi_decode #(
        .ADDR_W   (BSI_ADDR_W),
        .IO_W     (BSI_IO_W),
        .RAM_AW   (RAM_AW),
        .PORT_BITS(BSI_PORT_BITS),
        .MEM_BASE (MEM_BASE),
        .IO_BASE  (IO_BASE)
    ) u_decode (
        .addr    (bus_addr),
        .mem_hit (mem_hit),
        .io_hit  (io_hit),
        .ram_word(dec_word),
        .port_sel(dec_port)
    );

    assign port_e  = bsi_port_e'(dec_port);
    assign mem_cmd = bus_mem_rd | bus_mem_wr;
    assign io_cmd  = bus_io_rd | bus_io_wr;
    assign cmd_any = mem_cmd | io_cmd;
    assign mem_go  = (state_q == ST_IDLE) && mem_cmd && mem_hit;
    assign io_go   = (state_q == ST_IDLE) && !mem_go && io_cmd && io_hit;

    assign in_wr   = io_go && bus_io_wr && (port_e == PORT_MBOX);
    assign out_rd  = io_go && bus_io_rd && (port_e == PORT_MBOX);
    assign irq_set = io_go && bus_io_wr && (port_e == PORT_IRQ);

    bsi_mbox #(.W(DATA_W)) u_mbox_in (
        .clk  (clk),
        .rst_n(rst_n),
        .wr   (in_wr),
        .wdata(bus_wdata),
        .rd   (core_mb_rd),
        .data (core_mb_rdata),
        .full (core_in_full),
        .ovr  (in_ovr_w)
    );

    bsi_mbox #(.W(DATA_W)) u_mbox_out (
        .clk  (clk),
        .rst_n(rst_n),
        .wr   (core_mb_wr),
        .wdata(core_mb_wdata),
        .rd   (out_rd),
        .data (out_data),
        .full (core_out_full),
        .ovr  (out_ovr_w)
    );

    bsi_irq #(.LEVELS(IRQ_LEVELS)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (irq_set),
        .set_bits(bus_wdata[IRQ_LEVELS-1:0]),
        .ack     (core_irq_ack),
        .pend    (irq_pend),
        .req     (core_irq_req),
        .lvl     (core_irq_lvl)
    );

    // Next-state logic and state register
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (mem_go) begin
                    state_d = ST_HOLD_WAIT;
                end else if (io_go) begin
                    state_d = ST_IO_DONE;
                end
            end
            ST_HOLD_WAIT: begin
                if (core_hold_ack) begin
                    state_d = ST_RAM_XFER;
                end
            end
            ST_RAM_XFER: state_d = ST_MEM_DONE;
            ST_MEM_DONE, ST_IO_DONE: begin
                if (!cmd_any) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Read word of the addressed I/O port
    always_comb begin
        io_rword = '0;
        unique case (port_e)
            PORT_MBOX: io_rword = out_data;
            PORT_STAT: io_rword[3:0] = {out_ovr_w, in_ovr_w, core_out_full, core_in_full};
            PORT_IRQ:  io_rword[IRQ_LEVELS-1:0] = irq_pend;
            PORT_RSVD: io_rword = '0;
            default:   io_rword = '0;
        endcase
    end

    // Cycle latches and read data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_word  <= '0;
            lat_wdata <= '0;
            lat_wr    <= 1'b0;
            lat_wide  <= 1'b0;
            rdata_q   <= '0;
        end else begin
            if (mem_go) begin
                lat_word  <= dec_word;
                lat_wdata <= bus_wdata;
                lat_wr    <= bus_mem_wr;
                lat_wide  <= bus_wide;
            end
            if (io_go && bus_io_rd) begin
                rdata_q <= io_rword;
            end
            if (state_q == ST_RAM_XFER) begin
                rdata_q <= lat_wide ? ram_rdata
                                    : {{(DATA_W-BYTE_W){1'b0}}, ram_rdata[BYTE_W-1:0]};
            end
        end
    end

    // Outputs decoded from state
    always_comb begin
        core_hold_req = 1'b0;
        bus_ack       = 1'b0;
        ram_en        = 1'b0;
        ram_we        = 1'b0;
        unique case (state_q)
            ST_IDLE:      ;
            ST_HOLD_WAIT: core_hold_req = 1'b1;
            ST_RAM_XFER: begin
                core_hold_req = 1'b1;
                ram_en        = 1'b1;
                ram_we        = lat_wr;
            end
            ST_MEM_DONE: begin
                core_hold_req = 1'b1;
                bus_ack       = 1'b1;
            end
            ST_IO_DONE:   bus_ack = 1'b1;
            default:      ;
        endcase
        ram_addr  = lat_word;
        ram_wdata = lat_wdata;
        ram_be    = lat_wide ? 2'b11 : 2'b01;
        bus_rdata = rdata_q;
    end

endmodule

// File: rtl/bsi_slave_chk.sv
module bsi_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic bus_ack,
    input logic core_hold_req,
    input logic core_hold_ack,
    input logic ram_en,
    input logic bus_mem_rd,
    input logic bus_mem_wr,
    input logic bus_io_rd,
    input logic bus_io_wr,
    input logic core_in_full,
    input logic in_ovr,
    input logic out_ovr
);

    logic cmd_any;
    assign cmd_any = bus_mem_rd | bus_mem_wr | bus_io_rd | bus_io_wr;

    // R3: RAM is touched only after the grant was sampled
    assert_ram_granted_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ram_en |-> $past(core_hold_ack));

    // R3: memory acknowledge follows the RAM strobe
    assert_ack_after_ram_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(bus_ack) && core_hold_req) |-> $past(ram_en));

    // R5: acknowledge held while command present
    assert_ack_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ack && cmd_any) |=> bus_ack);

    // R5: acknowledge and hold drop after command removal
    assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ack && !cmd_any) |=> (!bus_ack && !core_hold_req));

    // R11: strobe only inside hold
    assert_strobe_in_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ram_en |-> core_hold_req);

    // R11: an acknowledge without hold belongs to an I/O cycle
    assert_io_no_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ack && !core_hold_req) |-> ($past(bus_io_rd) || $past(bus_io_wr)));

    // R7: inbound full flag rises only from a bus I/O write
    assert_full_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_in_full) |-> $past(bus_io_wr));

    // R7: bus-side overrun is sticky
    assert_ovr_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_ovr |=> in_ovr);

    // R8: core-side overrun is sticky
    assert_ovr_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_ovr |=> out_ovr);

endmodule

bind bsi_slave bsi_slave_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_ack      (bus_ack),
    .core_hold_req(core_hold_req),
    .core_hold_ack(core_hold_ack),
    .ram_en       (ram_en),
    .bus_mem_rd   (bus_mem_rd),
    .bus_mem_wr   (bus_mem_wr),
    .bus_io_rd    (bus_io_rd),
    .bus_io_wr    (bus_io_wr),
    .core_in_full (core_in_full),
    .in_ovr       (in_ovr_w),
    .out_ovr      (out_ovr_w)
);

// File: tb/bsi_slave_bench.sv
`timescale 1ns/1ps
module bsi_slave_bench;

    localparam logic [23:0] MBASE = 24'h040000;
    localparam logic [15:0] IBASE = 16'h0080;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        bus_wide = 1'b1;
    logic        bus_mem_rd = 1'b0, bus_mem_wr = 1'b0, bus_io_rd = 1'b0, bus_io_wr = 1'b0;
    logic [15:0] bus_rdata;
    logic        bus_ack;
    logic        core_hold_req;
    logic        core_hold_ack = 1'b0;
    logic [11:0] ram_addr;
    logic [15:0] ram_wdata;
    logic [1:0]  ram_be;
    logic        ram_en, ram_we;
    logic [15:0] ram_rdata;
    logic        core_mb_rd = 1'b0;
    logic [15:0] core_mb_rdata;
    logic        core_in_full;
    logic        core_mb_wr = 1'b0;
    logic [15:0] core_mb_wdata = '0;
    logic        core_out_full;
    logic        core_irq_req;
    logic [1:0]  core_irq_lvl;
    logic        core_irq_ack = 1'b0;

    int n_chk = 0;
    int n_err = 0;
    int hd = 0;
    int hcnt = 0;

    logic [15:0] ram   [0:4095];
    logic [15:0] shadow[0:4095];

    always #2.5 clk = ~clk;

    bsi_slave u_bsi_slave (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wide(bus_wide), .bus_mem_rd(bus_mem_rd), .bus_mem_wr(bus_mem_wr),
        .bus_io_rd(bus_io_rd), .bus_io_wr(bus_io_wr), .bus_rdata(bus_rdata),
        .bus_ack(bus_ack), .core_hold_req(core_hold_req), .core_hold_ack(core_hold_ack),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_be(ram_be), .ram_en(ram_en),
        .ram_we(ram_we), .ram_rdata(ram_rdata), .core_mb_rd(core_mb_rd),
        .core_mb_rdata(core_mb_rdata), .core_in_full(core_in_full),
        .core_mb_wr(core_mb_wr), .core_mb_wdata(core_mb_wdata),
        .core_out_full(core_out_full), .core_irq_req(core_irq_req),
        .core_irq_lvl(core_irq_lvl), .core_irq_ack(core_irq_ack)
    );

    // Shared RAM model
    assign ram_rdata = ram[ram_addr];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4096; i++) ram[i] <= '0;
        end else if (ram_en && ram_we) begin
            if (ram_be[0]) ram[ram_addr][7:0]  <= ram_wdata[7:0];
            if (ram_be[1]) ram[ram_addr][15:8] <= ram_wdata[15:8];
        end
    end

    // Core model: grants hold hd cycles late
    always @(negedge clk) begin
        if (!core_hold_req) begin
            hcnt = 0;
            core_hold_ack = 1'b0;
        end else begin
            hcnt = hcnt + 1;
            if (hcnt > hd) core_hold_ack = 1'b1;
        end
    end

    function automatic logic [15:0] exp_read(input logic [15:0] word, input logic wide);
        return wide ? word : {8'h00, word[7:0]};
    endfunction

    function automatic logic [15:0] exp_merge(input logic [15:0] old, input logic [15:0] nw,
                                              input logic wide);
        return wide ? nw : {old[15:8], nw[7:0]};
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    endtask

    task automatic mem_access(input bit wr, input logic [23:0] a, input bit wide,
                              input logic [15:0] d, input int hdel,
                              output logic [15:0] rd, output int lat);
        @(negedge clk);
        hd = hdel;
        bus_addr = a; bus_wdata = d; bus_wide = wide;
        if (wr) bus_mem_wr = 1'b1; else bus_mem_rd = 1'b1;
        lat = 0;
        while (!bus_ack && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        rd = bus_rdata;
        bus_mem_wr = 1'b0; bus_mem_rd = 1'b0;
        @(negedge clk);
        check("R5", "ack after release", {31'd0, bus_ack}, 32'd0);
        check("R5", "hold after release", {31'd0, core_hold_req}, 32'd0);
    endtask

    task automatic io_access(input bit wr, input logic [1:0] port, input logic [15:0] d,
                             output logic [15:0] rd, output int lat);
        bit held;
        @(negedge clk);
        bus_addr = {8'h00, IBASE[15:2], port}; bus_wdata = d;
        if (wr) bus_io_wr = 1'b1; else bus_io_rd = 1'b1;
        lat = 0; held = 1'b0;
        while (!bus_ack && lat < 40) begin
            @(negedge clk);
            lat++;
            if (core_hold_req) held = 1'b1;
        end
        rd = bus_rdata;
        bus_io_wr = 1'b0; bus_io_rd = 1'b0;
        check("R11", "hold during io", {31'd0, held}, 32'd0);
        @(negedge clk);
        check("R5", "io ack after release", {31'd0, bus_ack}, 32'd0);
    endtask

    task automatic miss_cycle(input bit mem, input bit wr, input logic [23:0] a,
                              input logic [15:0] d);
        bit seen;
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wide = 1'b1; seen = 1'b0;
        if (mem) begin
            if (wr) bus_mem_wr = 1'b1; else bus_mem_rd = 1'b1;
        end else begin
            if (wr) bus_io_wr = 1'b1; else bus_io_rd = 1'b1;
        end
        repeat (6) begin
            @(negedge clk);
            if (bus_ack || core_hold_req || ram_en) seen = 1'b1;
        end
        bus_mem_wr = 1'b0; bus_mem_rd = 1'b0; bus_io_wr = 1'b0; bus_io_rd = 1'b0;
        check("R2", "miss response", {31'd0, seen}, 32'd0);
    endtask

    task automatic pulse_core(input int which);
        @(negedge clk);
        case (which)
            0: core_mb_rd = 1'b1;
            1: core_mb_wr = 1'b1;
            default: core_irq_ack = 1'b1;
        endcase
        @(negedge clk);
        core_mb_rd = 1'b0; core_mb_wr = 1'b0; core_irq_ack = 1'b0;
    endtask

    initial begin
        #1_000_000;
        n_err++;
        $display("FAIL watchdog run did not complete");
        finish_run();
    end

    initial begin
        logic [15:0] rd;
        int lat;
        for (int i = 0; i < 4096; i++) shadow[i] = '0;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1", "ack", {31'd0, bus_ack}, 32'd0);
        check("R1", "hold", {31'd0, core_hold_req}, 32'd0);
        check("R1", "ram_en", {31'd0, ram_en}, 32'd0);
        check("R1", "flags", {30'd0, core_in_full, core_out_full}, 32'd0);
        check("R1", "irq", {31'd0, core_irq_req}, 32'd0);
        io_access(1'b0, 2'd1, 16'h0, rd, lat);
        check("R1", "status", {16'd0, rd}, 32'd0);

        // R3/R4 wide write, immediate grant
        mem_access(1'b1, MBASE | 24'h005, 1'b1, 16'hA55A, 0, rd, lat);
        check("R3", "mem write latency h0", lat, 32'd3);
        shadow[5] = 16'hA55A;
        mem_access(1'b0, MBASE | 24'h005, 1'b1, 16'h0, 0, rd, lat);
        check("R4", "wide read", {16'd0, rd}, {16'd0, 16'hA55A});

        // R4 byte write keeps high byte, byte read zero-extends
        mem_access(1'b1, MBASE | 24'h005, 1'b0, 16'hFF3C, 1, rd, lat);
        shadow[5] = exp_merge(shadow[5], 16'hFF3C, 1'b0);
        mem_access(1'b0, MBASE | 24'h005, 1'b1, 16'h0, 0, rd, lat);
        check("R4", "after byte write", {16'd0, rd}, {16'd0, shadow[5]});
        mem_access(1'b0, MBASE | 24'h005, 1'b0, 16'h0, 0, rd, lat);
        check("R4", "byte read", {16'd0, rd}, {16'd0, exp_read(shadow[5], 1'b0)});

        // R3 late grant
        mem_access(1'b0, MBASE | 24'h005, 1'b1, 16'h0, 3, rd, lat);
        check("R3", "mem latency h3", lat, 32'd6);

        // R2 misses: aliasing memory write and I/O outside window
        miss_cycle(1'b1, 1'b1, 24'h041005, 16'h1234);
        miss_cycle(1'b0, 1'b1, 24'h000084, 16'h0001);
        miss_cycle(1'b0, 1'b1, 24'h000082 ^ 24'h000100, 16'h000F);
        mem_access(1'b0, MBASE | 24'h005, 1'b1, 16'h0, 0, rd, lat);
        check("R2", "ram unchanged after miss", {16'd0, rd}, {16'd0, shadow[5]});
        io_access(1'b0, 2'd1, 16'h0, rd, lat);
        check("R2", "status unchanged after miss", {16'd0, rd}, 32'd0);
        check("R2", "irq unchanged after miss", {31'd0, core_irq_req}, 32'd0);

        // R6/R7 inbound mailbox
        io_access(1'b1, 2'd0, 16'hBEEF, rd, lat);
        check("R6", "io latency", lat, 32'd1);
        check("R7", "in_full set", {31'd0, core_in_full}, 32'd1);
        check("R7", "in data", {16'd0, core_mb_rdata}, {16'd0, 16'hBEEF});
        io_access(1'b1, 2'd0, 16'h1111, rd, lat);
        check("R7", "overwrite ignored", {16'd0, core_mb_rdata}, {16'd0, 16'hBEEF});
        io_access(1'b0, 2'd1, 16'h0, rd, lat);
        check("R9", "status full+ovr", {16'd0, rd}, 32'h5);
        pulse_core(0);
        check("R7", "in_full cleared", {31'd0, core_in_full}, 32'd0);
        io_access(1'b0, 2'd1, 16'h0, rd, lat);
        check("R7", "overrun sticky", {16'd0, rd}, 32'h4);

        // R8 outbound mailbox
        core_mb_wdata = 16'h0C0D;
        pulse_core(1);
        check("R8", "out_full set", {31'd0, core_out_full}, 32'd1);
        core_mb_wdata = 16'h9999;
        pulse_core(1);
        io_access(1'b0, 2'd1, 16'h0, rd, lat);
        check("R9", "status out+ovr", {16'd0, rd}, 32'hE);
        io_access(1'b0, 2'd0, 16'h0, rd, lat);
        check("R8", "out data", {16'd0, rd}, {16'd0, 16'h0C0D});
        check("R8", "out_full cleared", {31'd0, core_out_full}, 32'd0);

        // R10 interrupts
        io_access(1'b1, 2'd2, 16'h0005, rd, lat);
        check("R10", "req", {31'd0, core_irq_req}, 32'd1);
        check("R10", "lvl 2", {30'd0, core_irq_lvl}, 32'd2);
        pulse_core(2);
        check("R10", "lvl 0 after ack", {30'd0, core_irq_lvl}, 32'd0);
        io_access(1'b1, 2'd2, 16'h0008, rd, lat);
        check("R10", "lvl 3", {30'd0, core_irq_lvl}, 32'd3);
        io_access(1'b0, 2'd2, 16'h0, rd, lat);
        check("R10", "pending read", {16'd0, rd}, 32'h9);
        pulse_core(2);
        pulse_core(2);
        check("R10", "req cleared", {31'd0, core_irq_req}, 32'd0);

        // Random memory traffic (R3, R4)
        for (int k = 0; k < 80; k++) begin
            bit wr, wide;
            logic [11:0] w;
            logic [15:0] d;
            int h;
            wr = 1'($urandom % 2);
            wide = 1'($urandom % 2);
            w = 12'($urandom % 16) + 12'h100;
            d = 16'($urandom);
            h = int'($urandom % 4);
            mem_access(wr, MBASE | {12'd0, w}, wide, d, h, rd, lat);
            check("R3", "random latency", lat, 32'(3 + h));
            if (wr) shadow[w] = exp_merge(shadow[w], d, wide);
            else check("R4", "random read", {16'd0, rd}, {16'd0, exp_read(shadow[w], wide)});
        end

        @(negedge clk);
        check("R11", "hold idle", {31'd0, core_hold_req}, 32'd0);
        finish_run();
    end

endmodule